// File: doc/BRIEF.md
# CAN Transmit Payload Stager with Alternating Byte Registers

This block keeps the header fields of one standard-format CAN transmit frame and hands its payload to a downstream bit-level serializer one byte at a time. A processor writes four 8-bit registers over a small register bus. Two of them are payload registers used in turn: the first feeds the odd-numbered bytes and the second feeds the even-numbered bytes. The other two hold the length code, the 11-bit identifier and the remote flag. The block assembles the identifier and works out how many payload bytes the frame really carries.

Each time the serializer takes a byte, the block moves to the other payload register. When the register just consumed will be needed again for a later byte of the same frame, the block raises a buffer-empty flag. Software refills that register while the other byte is being sent. If the serializer asks for a byte while the flag is still up, a sticky underrun bit is set. The block also turns each serial bit into the two pin-driver enables, and it has a control input that forces both drivers off.

Top module: `can_tx_stager`

## Requirements
- R1: A write with `bus_wr` high stores `bus_wdata` in the register chosen by `bus_addr`: 0 holds odd bytes, 1 holds even bytes, 2 holds the length/low-ID register and 3 holds the high-ID register. `bus_rdata` returns the stored value of the register that `bus_addr` selects.
- R2: `frame_id` is `{reg3[6:0], reg2[7:4]}`, `frame_rmt` is `reg3[7]` and `frame_dlc` is `reg2[3:0]`.
- R3: `frame_len` follows the length code, but a code above 8 counts as 8, and the length is 0 whenever `frame_rmt` is 1.
- R4: One cycle after a `tx_start` pulse, the byte index is 1: `next_sel` = 0, and `tbe` and `underrun` are both 0. `tx_start` takes priority over `byte_req` in the same cycle.
- R5: `byte_data` always shows the register at address 0 when `next_sel` = 0 and the register at address 1 when `next_sel` = 1. Each accepted `byte_req` toggles `next_sel`, so payload byte k comes from address 0 when k is odd and from address 1 when k is even.
- R6: `payload_done` is high once the byte index is greater than `frame_len`. While it is high, `byte_req` has no effect on `next_sel`, `tbe` or `underrun`.
- R7: Accepting byte k sets `tbe` one cycle later if k+2 ≤ `frame_len`. A write to the register that byte k came from clears `tbe`. A write to the other payload register does not clear it.
- R8: An accepted `byte_req` while `tbe` = 1 sets `underrun`. `underrun` stays set until `tx_start` or reset.
- R9: When `drv_off` = 0 and `ser_bit` = 0 (dominant), `pin_lo_en` and `pin_hi_en` are both 1. In every other case both are 0 (high impedance).
- R10: After reset every register reads 0, `next_sel`, `tbe` and `underrun` are 0, and `payload_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| tx_start | input | 1 | Start-of-transmission strobe |
| byte_req | input | 1 | Serializer takes the presented byte |
| byte_data | output | 8 | Payload byte currently presented |
| next_sel | output | 1 | Payload register that supplies the next byte (0 = odd, 1 = even) |
| payload_done | output | 1 | All payload bytes of the frame have been taken |
| tbe | output | 1 | Consumed register may be refilled |
| underrun | output | 1 | Sticky: a byte was taken while a refill was pending |
| frame_id | output | 11 | Assembled identifier |
| frame_rmt | output | 1 | Remote frame request |
| frame_dlc | output | 4 | Raw data length code |
| frame_len | output | 4 | Payload byte count in effect |
| ser_bit | input | 1 | Serial bit from the serializer (0 = dominant) |
| drv_off | input | 1 | Forces both drivers to high impedance |
| pin_lo_en | output | 1 | Enable for the driver that pulls low |
| pin_hi_en | output | 1 | Enable for the driver that pulls high |

## Verification
The assertions check the following on every cycle: the pin enables always agree, `drv_off` forces both enables off, `frame_len` never exceeds eight and is zero for remote frames, `next_sel` toggles on each accepted request, the state after a start pulse is correct, and `underrun` stays set once raised. Only the bench scenarios can show the exact byte order across several refills, the point at which `tbe` stops being raised near the end of a frame, the fact that writing the other register leaves `tbe` alone, and the register readback and identifier assembly for chosen values.

// File: rtl/can_stg_pkg.sv
// Shared register map and widths for the CAN transmit payload stager.
// Assumes a fixed 8-bit register bus with four registers.
package can_stg_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int ID_W   = 11;
    localparam int DLC_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA_ODD  = 2'd0,
        A_DATA_EVEN = 2'd1,
        A_LEN_IDLO  = 2'd2,
        A_IDHI_RMT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             rmt;
        logic [ID_W-1:0]  id;
        logic [DLC_W-1:0] dlc;
    } frame_hdr_t;
endpackage

// File: rtl/can_stg_regs.sv
// Register file: two payload registers, length/low-ID and high-ID/remote.
// Assumes single-cycle writes and a combinational read mux.
module can_stg_regs
    import can_stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] data_odd,
    output logic [BYTE_W-1:0] data_even,
    output frame_hdr_t        hdr
);
    logic [BYTE_W-1:0] regs_q [4];

    // Store written bytes; all registers clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[addr] <= wr_data;
        end
    end

    // Read mux and field extraction.
    always_comb begin
        rd_data   = regs_q[addr];
        data_odd  = regs_q[A_DATA_ODD];
        data_even = regs_q[A_DATA_EVEN];
        hdr.rmt   = regs_q[A_IDHI_RMT][7];
        hdr.id    = {regs_q[A_IDHI_RMT][6:0], regs_q[A_LEN_IDLO][7:4]};
        hdr.dlc   = regs_q[A_LEN_IDLO][DLC_W-1:0];
    end
endmodule

// File: rtl/can_stg_seq.sv
// Byte sequencer: byte index, alternation between the payload registers,
// buffer-empty flag and sticky underrun. Assumes that start outranks req.
module can_stg_seq
    import can_stg_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int IDX_W = $clog2(MAX_BYTES + 2)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rmt,
    input  logic [DLC_W-1:0]  dlc,
    output logic              sel,
    output logic              tbe,
    output logic              underrun,
    output logic              done,
    output logic [IDX_W-1:0]  eff_len
);
    logic [IDX_W-1:0] idx_q;
    logic             tbe_q, tbe_src_q, unr_q;
    logic             consume, refill_needed, refill_write;

    // Number of payload bytes in effect: clamped, zero for remote frames.
    always_comb begin
        if (rmt)                         eff_len = '0;
        else if (int'(dlc) > MAX_BYTES)  eff_len = IDX_W'(MAX_BYTES);
        else                             eff_len = IDX_W'(dlc);
    end

    // Decode acceptance, refill need and a write that refills the emptied register.
    always_comb begin
        done          = (idx_q > eff_len);
        sel           = ~idx_q[0];
        consume       = req && !done && !start;
        refill_needed = (({1'b0, idx_q} + (IDX_W+1)'(2)) <= {1'b0, eff_len});
        refill_write  = wr_en && (wr_addr == (tbe_src_q ? A_DATA_EVEN : A_DATA_ODD));
    end

    // Byte index: 1 after reset or start, advances per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || start) idx_q <= IDX_W'(1);
        else if (consume)    idx_q <= idx_q + IDX_W'(1);
    end

    // Buffer-empty flag and the register it refers to.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            tbe_q     <= 1'b0;
            tbe_src_q <= 1'b0;
        end else if (consume && refill_needed) begin
            tbe_q     <= 1'b1;
            tbe_src_q <= sel;
        end else if (tbe_q && refill_write) begin
            tbe_q     <= 1'b0;
        end
    end

    // Sticky underrun: a byte taken while a refill was still pending.
    always_ff @(posedge clk) begin
        if (!rst_n || start)     unr_q <= 1'b0;
        else if (consume && tbe_q) unr_q <= 1'b1;
    end

    assign tbe      = tbe_q;
    assign underrun = unr_q;
endmodule

// File: rtl/can_stg_pins.sv
// Maps a serial bit to the two pin-driver enables. Dominant (0) enables
// both drivers; recessive or a forced-off control leaves both disabled.
module can_stg_pins (
    input  logic bit_in,
    input  logic force_off,
    output logic lo_en,
    output logic hi_en
);
    // Driver enable decode.
    always_comb begin
        lo_en = !force_off && !bit_in;
        hi_en = !force_off && !bit_in;
    end
endmodule

// File: rtl/can_tx_stager.sv
// Top of the CAN transmit payload stager. Connects the register file,
// the byte sequencer and the pin mapping. Assumes the serializer samples
// byte_data in the cycle it raises byte_req.
module can_tx_stager
    import can_stg_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int IDX_W = $clog2(MAX_BYTES + 2)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tx_start,
    input  logic              byte_req,
    output logic [BYTE_W-1:0] byte_data,
    output logic              next_sel,
    output logic              payload_done,
    output logic              tbe,
    output logic              underrun,
    output logic [ID_W-1:0]   frame_id,
    output logic              frame_rmt,
    output logic [DLC_W-1:0]  frame_dlc,
    output logic [IDX_W-1:0]  frame_len,
    input  logic              ser_bit,
    input  logic              drv_off,
    output logic              pin_lo_en,
    output logic              pin_hi_en
);
    logic [BYTE_W-1:0] data_odd, data_even;
    frame_hdr_t        hdr;

    can_stg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wr_data(bus_wdata), .rd_data(bus_rdata),
        .data_odd(data_odd), .data_even(data_even), .hdr(hdr)
    );

    can_stg_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .req(byte_req),
        .wr_en(bus_wr), .wr_addr(bus_addr), .rmt(hdr.rmt), .dlc(hdr.dlc),
        .sel(next_sel), .tbe(tbe), .underrun(underrun),
        .done(payload_done), .eff_len(frame_len)
    );

    can_stg_pins u_pins (
        .bit_in(ser_bit), .force_off(drv_off),
        .lo_en(pin_lo_en), .hi_en(pin_hi_en)
    );

    // Present the byte from the selected payload register and the header fields.
    always_comb begin
        byte_data = next_sel ? data_even : data_odd;
        frame_id  = hdr.id;
        frame_rmt = hdr.rmt;
        frame_dlc = hdr.dlc;
    end
endmodule

// File: rtl/can_tx_stager_chk.sv
// Checker for can_tx_stager, bound to every instance. Observes ports only.
module can_tx_stager_chk
    import can_stg_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int IDX_W = $clog2(MAX_BYTES + 2)
)(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              tx_start,
    input logic              byte_req,
    input logic [BYTE_W-1:0] byte_data,
    input logic              next_sel,
    input logic              payload_done,
    input logic              tbe,
    input logic              underrun,
    input logic [ID_W-1:0]   frame_id,
    input logic              frame_rmt,
    input logic [DLC_W-1:0]  frame_dlc,
    input logic [IDX_W-1:0]  frame_len,
    input logic              ser_bit,
    input logic              drv_off,
    input logic              pin_lo_en,
    input logic              pin_hi_en
);
    // R9
    pins_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_lo_en == pin_hi_en);
    // R9
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off |-> (!pin_lo_en && !pin_hi_en));
    // R3
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_len) <= MAX_BYTES);
    // R3
    rmt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rmt |-> (frame_len == '0));
    // R4
    start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (!next_sel && !tbe && !underrun));
    // R5
    sel_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !payload_done && !tx_start) |=> (next_sel != $past(next_sel)));
    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && payload_done && !tx_start) |=> $stable(next_sel));
    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !tx_start) |=> underrun);
endmodule

bind can_tx_stager can_tx_stager_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (.*);

// File: tb/can_tx_stager_bench.sv
`timescale 1ns/1ps
module can_tx_stager_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_start = 1'b0, byte_req = 1'b0;
    logic [7:0] byte_data;
    logic       next_sel, payload_done, tbe, underrun;
    logic [10:0] frame_id;
    logic       frame_rmt;
    logic [3:0] frame_dlc, frame_len;
    logic       ser_bit = 1'b1, drv_off = 1'b0;
    logic       pin_lo_en, pin_hi_en;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    can_tx_stager u_can_tx_stager (.*);

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic pulse_start();
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); byte_req = 1'b1;
        @(negedge clk); byte_req = 1'b0;
    endtask

    // R10: state after reset.
    task automatic t_reset();
        chk("R10 next_sel", next_sel, 0);
        chk("R10 tbe", tbe, 0);
        chk("R10 underrun", underrun, 0);
        chk("R10 payload_done", payload_done, 1);
        for (int a = 0; a < 4; a++) rd_chk(2'(a), 0, "R10 reg");
    endtask

    // R1, R2: readback and field assembly.
    task automatic t_regs();
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h9B); wr(2'd3, 8'hD6);
        rd_chk(2'd0, 8'hA5, "R1 odd");
        rd_chk(2'd1, 8'h3C, "R1 even");
        rd_chk(2'd2, 8'h9B, "R1 len/idlo");
        rd_chk(2'd3, 8'hD6, "R1 idhi");
        chk("R2 id", frame_id, {7'h56, 4'h9});
        chk("R2 rmt", frame_rmt, 1);
        chk("R2 dlc", frame_dlc, 4'hB);
    endtask

    // R3: clamp and remote length.
    task automatic t_len();
        chk("R3 rmt len", frame_len, 0);
        wr(2'd3, 8'h12);
        #1 chk("R3 clamp", frame_len, 8);
        wr(2'd2, 8'h75);
        #1 chk("R3 plain", frame_len, 5);
        wr(2'd2, 8'h70);
        #1 chk("R3 zero", frame_len, 0);
    endtask

    // R4..R7: five-byte frame with refills.
    task automatic t_stream();
        wr(2'd2, 8'h05); wr(2'd0, 8'h11); wr(2'd1, 8'h22);
        pulse_start();
        chk("R4 sel", next_sel, 0);
        chk("R4 tbe", tbe, 0);
        chk("R4 done", payload_done, 0);
        chk("R5 byte1", byte_data, 8'h11);
        pulse_req();
        chk("R7 tbe set b1", tbe, 1);
        chk("R5 sel b2", next_sel, 1);
        chk("R5 byte2", byte_data, 8'h22);
        wr(2'd1, 8'h22);
        chk("R7 other write keeps", tbe, 1);
        wr(2'd0, 8'h33);
        chk("R7 cleared", tbe, 0);
        pulse_req();
        chk("R7 tbe set b2", tbe, 1);
        chk("R5 byte3", byte_data, 8'h33);
        wr(2'd1, 8'h44);
        pulse_req();
        chk("R7 tbe set b3", tbe, 1);
        chk("R5 byte4", byte_data, 8'h44);
        wr(2'd0, 8'h55);
        chk("R7 cleared b3", tbe, 0);
        pulse_req();
        chk("R7 no set b4", tbe, 0);
        chk("R5 byte5", byte_data, 8'h55);
        chk("R5 sel b5", next_sel, 0);
        pulse_req();
        chk("R6 done", payload_done, 1);
        chk("R7 no set b5", tbe, 0);
        pulse_req();
        chk("R6 sel held", next_sel, 1);
        chk("R6 tbe held", tbe, 0);
        chk("R6 underrun held", underrun, 0);
    endtask

    // R8, R4: underrun and its clearing by start.
    task automatic t_underrun();
        wr(2'd2, 8'h08);
        pulse_start();
        pulse_req();
        chk("R8 tbe", tbe, 1);
        pulse_req();
        chk("R8 underrun set", underrun, 1);
        wr(2'd0, 8'h01);
        pulse_req();
        chk("R8 sticky", underrun, 1);
        @(negedge clk); tx_start = 1'b1; byte_req = 1'b1;
        @(negedge clk); tx_start = 1'b0; byte_req = 1'b0;
        chk("R4 underrun cleared", underrun, 0);
        chk("R4 start wins", next_sel, 0);
        chk("R4 tbe cleared", tbe, 0);
    endtask

    // R9: pin mapping for all input combinations.
    task automatic t_pins();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ser_bit = i[0]; drv_off = i[1];
            #1;
            chk("R9 lo", pin_lo_en, (i == 0) ? 1 : 0);
            chk("R9 hi", pin_hi_en, (i == 0) ? 1 : 0);
        end
        drv_off = 1'b0; ser_bit = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_len();
        t_stream();
        t_underrun();
        t_pins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule